// File: doc/BRIEF.md
# Non-Audio Stream Auto-Detector

This block sits behind the subframe decoder of a two-channel digital audio receiver. It watches each decoded audio word as it arrives and flags the stream as compressed (non-audio) data when it sees the two-word burst preamble used by compressed-audio-over-PCM transports. It has to look at the data itself because some sources leave the channel-status non-audio bit clear even when they send compressed bursts.

Once a preamble has been seen, the detect flag stays high. Each further preamble re-arms a frame-count timeout. When a set number of frames passes with no preamble, the flag drops and stays low until the next preamble. The final non-audio indication is the detect flag ORed with the received channel-status bit 1. When automatic de-emphasis selection is enabled, that indication also asks for the de-emphasis filter to be bypassed. The sample words pass through with one register of latency and are never altered or muted. Muting, if wanted, is left to downstream logic.

Top module: `nonaudio_autodetect`

## Requirements
- R1: While `rst` is high at a clock edge, `detect` and `out_valid` are low after that edge. The preamble matcher and the frame counter also return to their idle state.
- R2: Preamble recognition uses only the top 16 bits of `in_word` (bits DATA_W-1 down to DATA_W-16). A valid subframe whose top bits are 16'hF872, followed by the next valid subframe with top bits 16'h4E1F, sets `detect` on the clock edge that accepts the second word. The low-order bits do not matter.
- R3: A preamble split across a frame boundary is accepted: 16'hF872 in a right subframe followed by 16'h4E1F in the next left subframe (with `in_frame_start` high) sets `detect`.
- R4: A partial match resets the matcher. If 16'hF872 is followed by any other valid word, a later 16'h4E1F does not set `detect`. A second 16'hF872 re-arms the matcher, so 16'hF872, 16'hF872, 16'h4E1F is accepted.
- R5: Cycles with `in_valid` low are ignored. They neither break a partial match nor count as a frame, whatever the values on `in_word` and `in_frame_start`.
- R6: After the last preamble, `detect` falls on the FRAME_LIMIT-th following accepted frame start (a valid subframe with `in_frame_start` high). It then stays low until a new preamble is found.
- R7: Every accepted preamble restarts the timeout, including one whose second word carries a frame start. `detect` then stays high for a full FRAME_LIMIT further frame starts.
- R8: `nonaudio` is high whenever `detect` is high or `cs_nonaudio` (received channel-status bit 1) is high, and low otherwise.
- R9: `deemph_bypass` is high exactly when `deemph_auto_en` is high and `nonaudio` is high.
- R10: `out_valid` and `out_word` repeat `in_valid` and `in_word` one clock later, unchanged, whether or not non-audio is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking one decoded subframe word |
| in_word | input | DATA_W | Decoded audio word of the subframe |
| in_frame_start | input | 1 | High on the first (left) subframe of a frame |
| cs_nonaudio | input | 1 | Received channel-status bit 1 |
| deemph_auto_en | input | 1 | Enables automatic de-emphasis selection |
| out_valid | output | 1 | Delayed copy of in_valid |
| out_word | output | DATA_W | Delayed, unmodified copy of in_word |
| detect | output | 1 | Preamble-based non-audio detect flag |
| nonaudio | output | 1 | detect OR cs_nonaudio |
| deemph_bypass | output | 1 | Request to bypass the de-emphasis filter |

## Verification
A matcher left armed by mistake shows up as `detect` rising on the edge of a stray 16'h4E1F word. A matcher that fails to arm shows up as `detect` staying low on the edge where the second preamble word is accepted. A frame counter that is off by one, or that is not reloaded, moves the falling edge of `detect` by one or more frames. For that reason the benches check `detect` just before and exactly at the FRAME_LIMIT-th frame start after a preamble. Errors in the pass-through path or the flag gating appear on the very next edge, or in the same cycle.

// File: rtl/nad_pkg.sv
package nad_pkg;

    localparam int SYNC_W = 16;
    localparam logic [SYNC_W-1:0] PREAMBLE_HEAD = 16'hF872;
    localparam logic [SYNC_W-1:0] PREAMBLE_TAIL = 16'h4E1F;

    typedef enum logic {
        MATCH_IDLE  = 1'b0,
        MATCH_ARMED = 1'b1
    } match_state_e;

    typedef struct packed {
        logic sync_hit;
        logic frame_tick;
    } nad_evt_t;

    function automatic logic is_head(input logic [SYNC_W-1:0] w);
        return w == PREAMBLE_HEAD;
    endfunction

    function automatic logic is_tail(input logic [SYNC_W-1:0] w);
        return w == PREAMBLE_TAIL;
    endfunction

endpackage

// File: rtl/nad_matcher.sv
module nad_matcher
    import nad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_frame_start,
    input  logic [SYNC_W-1:0] sync_bits,
    output nad_evt_t          evt
);

    match_state_e state;

    always_comb begin
        evt.sync_hit   = in_valid && (state == MATCH_ARMED) && is_tail(sync_bits);
        evt.frame_tick = in_valid && in_frame_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MATCH_IDLE;
        end else if (in_valid) begin
            state <= is_head(sync_bits) ? MATCH_ARMED : MATCH_IDLE;
        end
    end

    // R5: idle cycles leave the matcher untouched
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state));

    // R4: any non-head valid word disarms
    a_r4_disarm: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_head(sync_bits)) |=> (state == MATCH_IDLE));

endmodule

// File: rtl/nad_timeout.sv
module nad_timeout
    import nad_pkg::*;
#(
    parameter int FRAME_LIMIT = 4096
) (
    input  logic     clk,
    input  logic     rst,
    input  nad_evt_t evt,
    output logic     detect
);

    localparam int CNT_W = $clog2(FRAME_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LIMIT - 1);

    logic [CNT_W-1:0] frames;

    always_ff @(posedge clk) begin
        if (rst) begin
            detect <= 1'b0;
            frames <= '0;
        end else if (evt.sync_hit) begin
            detect <= 1'b1;
            frames <= '0;
        end else if (detect && evt.frame_tick) begin
            if (frames == LAST) begin
                detect <= 1'b0;
                frames <= '0;
            end else begin
                frames <= frames + 1'b1;
            end
        end
    end

    // R2: an accepted preamble raises the flag on the next edge
    a_r2_sync_sets_detect: assert property (@(posedge clk) disable iff (rst)
        evt.sync_hit |=> (detect && frames == '0));

    // R6: the flag never rises without a preamble
    a_r6_no_rise_without_sync: assert property (@(posedge clk) disable iff (rst)
        (!detect && !evt.sync_hit) |=> !detect);

    // R6: the flag only falls on a frame start
    a_r6_fall_on_frame: assert property (@(posedge clk) disable iff (rst)
        (detect && !evt.frame_tick) |=> detect);

    // R7: the counter stays inside the window
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        frames <= LAST);

endmodule

// File: rtl/nad_passthru.sv
module nad_passthru #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            out_word  <= in_word;
        end
    end

endmodule

// File: rtl/nonaudio_autodetect.sv
module nonaudio_autodetect
    import nad_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int FRAME_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    input  logic              in_frame_start,
    input  logic              cs_nonaudio,
    input  logic              deemph_auto_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word,
    output logic              detect,
    output logic              nonaudio,
    output logic              deemph_bypass
);

    nad_evt_t evt;

    nad_matcher u_match (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_frame_start (in_frame_start),
        .sync_bits      (in_word[DATA_W-1 -: SYNC_W]),
        .evt            (evt)
    );

    nad_timeout #(.FRAME_LIMIT(FRAME_LIMIT)) u_timeout (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .detect (detect)
    );

    nad_passthru #(.DATA_W(DATA_W)) u_pass (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    always_comb begin
        nonaudio      = detect | cs_nonaudio;
        deemph_bypass = deemph_auto_en & nonaudio;
    end

    // R10: data passes unchanged with one register of delay
    a_r10_passthru: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_word == $past(in_word)));

    // R8: either source forces the non-audio indication
    a_r8_sources: assert property (@(posedge clk) disable iff (rst)
        (cs_nonaudio || detect) |-> nonaudio);

    // R9: no bypass request while auto-select is off
    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        !deemph_auto_en |-> !deemph_bypass);

endmodule

// File: tb/tb_nonaudio_autodetect.sv
module tb_nonaudio_autodetect;

    localparam int DW  = 24;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_word = '0;
    logic          in_frame_start = 1'b0;
    logic          cs_nonaudio = 1'b0;
    logic          deemph_auto_en = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_word;
    logic          detect, nonaudio, deemph_bypass;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    nonaudio_autodetect #(.DATA_W(DW), .FRAME_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_frame_start(in_frame_start), .cs_nonaudio(cs_nonaudio),
        .deemph_auto_en(deemph_auto_en), .out_valid(out_valid),
        .out_word(out_word), .detect(detect), .nonaudio(nonaudio),
        .deemph_bypass(deemph_bypass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_frame_start = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic send(input logic [15:0] top, input logic fs);
        @(negedge clk);
        in_valid = 1'b1; in_frame_start = fs; in_word = {top, 8'h5A};
        @(posedge clk); #1;
        in_valid = 1'b0; in_frame_start = 1'b0;
    endtask

    task automatic send_frames(input int n);
        for (int i = 0; i < n; i++) begin
            send(16'h1234, 1'b1);
            send(16'h4321, 1'b0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_word = {16'hF872, 8'h00};
        @(posedge clk); #1;
        chk(detect == 0 && out_valid == 0, "R1", {detect, out_valid}, 0);
        in_valid = 1'b0; rst = 1'b0;
        send(16'h4E1F, 1'b0);
        chk(detect == 0, "R1 matcher cleared", detect, 0);
    endtask

    task automatic t_basic();
        do_reset();
        send(16'hF872, 1'b1);
        chk(detect == 0, "R2 after head only", detect, 0);
        @(negedge clk);
        in_valid = 1'b1; in_frame_start = 1'b0; in_word = 24'h4E1FC3;
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(detect == 1, "R2 low bits ignored", detect, 1);
    endtask

    task automatic t_split();
        do_reset();
        send(16'hF872, 1'b0);
        send(16'h4E1F, 1'b1);
        chk(detect == 1, "R3 split pair", detect, 1);
    endtask

    task automatic t_partial();
        do_reset();
        send(16'hF872, 1'b1);
        send(16'h0000, 1'b0);
        send(16'h4E1F, 1'b1);
        chk(detect == 0, "R4 broken match", detect, 0);
        send(16'hF872, 1'b0);
        send(16'hF872, 1'b1);
        send(16'h4E1F, 1'b0);
        chk(detect == 1, "R4 rearm", detect, 1);
    endtask

    task automatic t_idle();
        do_reset();
        send(16'hF872, 1'b0);
        @(negedge clk);
        in_valid = 1'b0; in_frame_start = 1'b1; in_word = 24'h000000;
        repeat (3) @(posedge clk);
        #1; in_frame_start = 1'b0;
        send(16'h4E1F, 1'b0);
        chk(detect == 1, "R5 idle ignored", detect, 1);
        // idle frame-start pulses must not age the flag
        @(negedge clk);
        in_frame_start = 1'b1;
        repeat (2 * LIM) @(posedge clk);
        #1; in_frame_start = 1'b0;
        chk(detect == 1, "R5 idle not counted", detect, 1);
    endtask

    task automatic t_timeout();
        do_reset();
        send(16'hF872, 1'b1);
        send(16'h4E1F, 1'b0);
        send_frames(LIM - 1);
        chk(detect == 1, "R6 before limit", detect, 1);
        send(16'h1111, 1'b1);
        chk(detect == 0, "R6 at limit", detect, 0);
        send_frames(2 * LIM);
        chk(detect == 0, "R6 stays low", detect, 0);
    endtask

    task automatic t_retrigger();
        do_reset();
        send(16'hF872, 1'b1);
        send(16'h4E1F, 1'b0);
        send_frames(5);
        send(16'hF872, 1'b0);
        send(16'h4E1F, 1'b1);
        send(16'h2222, 1'b0);
        send_frames(LIM - 1);
        chk(detect == 1, "R7 reloaded", detect, 1);
        send(16'h3333, 1'b1);
        chk(detect == 0, "R7 expires after reload", detect, 0);
    endtask

    task automatic t_flags();
        do_reset();
        cs_nonaudio = 1'b0; deemph_auto_en = 1'b1; #1;
        chk(nonaudio == 0 && deemph_bypass == 0, "R8 R9 all clear", {nonaudio, deemph_bypass}, 0);
        cs_nonaudio = 1'b1; #1;
        chk(nonaudio == 1, "R8 cs bit", nonaudio, 1);
        chk(deemph_bypass == 1, "R9 bypass", deemph_bypass, 1);
        deemph_auto_en = 1'b0; #1;
        chk(deemph_bypass == 0, "R9 disabled", deemph_bypass, 0);
        cs_nonaudio = 1'b0;
        send(16'hF872, 1'b1);
        send(16'h4E1F, 1'b0);
        deemph_auto_en = 1'b1; #1;
        chk(nonaudio == 1 && deemph_bypass == 1, "R8 R9 from detect", {nonaudio, deemph_bypass}, 3);
        deemph_auto_en = 1'b0;
    endtask

    task automatic t_pass();
        do_reset();
        send(16'hF872, 1'b1);
        send(16'h4E1F, 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_word = 24'hABCDEF;
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(out_valid == 1 && out_word == 24'hABCDEF, "R10 data kept", int'(out_word), 24'hABCDEF);
        @(posedge clk); #1;
        chk(out_valid == 0, "R10 valid follows", out_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_split();
        t_partial();
        t_idle();
        t_timeout();
        t_retrigger();
        t_flags();
        t_pass();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule